// File: doc/BRIEF.md
# Memory Card Device State Tracker

This block is the device-side command state machine of an embedded flash card that sits on a shared command line. A command-line receiver sits in front of it. That receiver handles framing and CRC and hands over each decoded command as a one-cycle strobe with a command index and a 32-bit argument. The tracker follows the card through its bus states. It keeps the relative card address (RCA) that the host assigned, and for every command it reports whether a response must be sent and whether the command was illegal.

Selecting and deselecting the card depends on the address carried in the upper argument bits, and it behaves differently in two pairs of states. In the stand-by/transfer pair, the card is selected and released. In the disconnect/programming pair, the card resumes and leaves a write in progress. Completion of internal programming is signalled from outside through a busy-done strobe. Data-line transfers, CRC and flash management belong to other blocks.

The outcome of a command appears one clock after its strobe as a one-cycle `rsp_valid` pulse, together with `rsp_due` and `cmd_illegal`. The new state and RCA appear on the same cycle. An illegal command never gets a response and never changes state.

Top module: `mmc_state_tracker`

## Requirements
- R1: After reset, `card_state` is 0 (idle), `card_rca` is 0 and `rsp_valid` is low. State codes: idle 0, ready 1, identification 2, stand-by 3, transfer 4, programming 7, disconnect 8, boot 10.
- R2: Before an RCA is assigned, three commands each respond and advance the state: index 1 moves idle to ready, index 2 moves ready to identification, and index 3 moves identification to stand-by while storing argument bits [31:16] as the RCA. Outcomes come one clock after `cmd_valid`.
- R3: Index 3 in identification whose argument bits [31:16] are zero is illegal. The state stays in identification and no RCA is stored.
- R4: Index 7 in stand-by moves the card to transfer with a response when argument bits [31:16] equal the RCA. Any other address leaves it in stand-by with no response and no illegal flag.
- R5: Index 7 in transfer with an address other than the RCA, including 0x0000, returns the card to stand-by with no response.
- R6: Index 7 in transfer with the card's own RCA is illegal and leaves the state unchanged.
- R7: Index 7 in disconnect with the own RCA moves the card to programming with a response. Index 7 in programming with any other address moves it to disconnect with no response.
- R8: Index 7 in programming with the own RCA is illegal and leaves the state unchanged.
- R9: Once an RCA is assigned, indexes 1, 2 and 3 get no response and no illegal flag, and leave both the state and the RCA unchanged.
- R10: Index 0 with argument 0x00000000 returns the card to idle from any state, clears the RCA and sends no response.
- R11: Index 0 with argument 0xFFFFFFFA in idle enters boot (10). In any other state it acts as a reset to idle. In boot, every other command is ignored silently and only index 0 leaves.
- R12: Index 24 or 25 in transfer moves the card to programming with a response. A `busy_done` pulse moves programming to transfer and disconnect to stand-by, and has no effect in other states or in a cycle that carries a command.
- R13: Index 13 in stand-by, transfer, programming or disconnect responds without changing state when the address matches the RCA. With another address it is silent and not illegal.
- R14: An unsupported index, or a command not allowed in the current state (for example index 24 in stand-by), is illegal, gets no response and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| busy_done | input | 1 | Internal programming has finished |
| rsp_valid | output | 1 | Outcome of the previous command is on the outputs |
| rsp_due | output | 1 | A response must be sent for that command |
| cmd_illegal | output | 1 | That command was illegal |
| card_state | output | 4 | Current bus state code |
| card_rca | output | 16 | Assigned relative card address (0 when none) |

## Verification
The bench builds the block with its defaults: a 6-bit index, a 32-bit argument, a 16-bit RCA in bits [31:16], the boot argument 0xFFFFFFFA, and rejection of a zero RCA enabled. These values let the bench reach the zero-address rejection during identification and the reserved 0x0000 deselect path. They also let it exercise the boot argument both from idle and from stand-by, and show that a plain reset cannot be confused with boot entry. The bench walks the card through every state, including the disconnect/programming pair, so that each CMD7 address case is seen in both state pairs.

// File: rtl/mmcst_pkg.sv
package mmcst_pkg;

   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_READY = 4'd1,
      ST_IDENT = 4'd2,
      ST_STBY  = 4'd3,
      ST_TRAN  = 4'd4,
      ST_PRG   = 4'd7,
      ST_DIS   = 4'd8,
      ST_BOOT  = 4'd10
   } mmcst_state_e;

   localparam int unsigned OP_GO      = 0;
   localparam int unsigned OP_OPCOND  = 1;
   localparam int unsigned OP_ALLID   = 2;
   localparam int unsigned OP_SETADDR = 3;
   localparam int unsigned OP_SELECT  = 7;
   localparam int unsigned OP_STATUS  = 13;
   localparam int unsigned OP_WR_ONE  = 24;
   localparam int unsigned OP_WR_MANY = 25;

   function automatic logic is_addressed_state(mmcst_state_e s);
      return (s == ST_STBY) || (s == ST_TRAN) || (s == ST_PRG) || (s == ST_DIS);
   endfunction

endpackage

// File: rtl/mmcst_addr_match.sv
module mmcst_addr_match #(
   parameter int unsigned RCA_W = 16
) (
   input  logic [RCA_W-1:0] field_i,
   input  logic [RCA_W-1:0] rca_i,
   input  logic             rca_set_i,
   output logic             own_o,
   output logic             zero_o
);
   assign zero_o = (field_i == '0);
   assign own_o  = rca_set_i && (field_i == rca_i);
endmodule

// File: rtl/mmcst_rca_reg.sv
module mmcst_rca_reg #(
   parameter int unsigned RCA_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             clear_i,
   input  logic [RCA_W-1:0] din_i,
   output logic [RCA_W-1:0] rca_o,
   output logic             rca_set_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rca_o     <= '0;
         rca_set_o <= 1'b0;
      end else if (clear_i) begin
         rca_o     <= '0;
         rca_set_o <= 1'b0;
      end else if (load_i) begin
         rca_o     <= din_i;
         rca_set_o <= 1'b1;
      end
   end

   // R10: clearing wipes the address
   a_r10_rca_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (rca_o == '0) && !rca_set_o);
   // R9: without a load or clear, the address holds
   a_r9_rca_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !clear_i) |=> $stable(rca_o));
endmodule

// File: rtl/mmcst_fsm.sv
module mmcst_fsm
   import mmcst_pkg::*;
#(
   parameter int unsigned IDX_W           = 6,
   parameter int unsigned ARG_W           = 32,
   parameter logic [31:0] BOOT_ARG        = 32'hFFFF_FFFA,
   parameter bit          ZERO_RCA_REJECT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [ARG_W-1:0] arg_i,
   input  logic             busy_done_i,
   input  logic             own_i,
   input  logic             zero_i,
   input  logic             rca_set_i,
   output logic             rca_load_o,
   output logic             rca_clear_o,
   output mmcst_state_e     state_o,
   output logic             rsp_valid_o,
   output logic             rsp_due_o,
   output logic             illegal_o
);
   localparam logic [IDX_W-1:0] C_GO      = IDX_W'(OP_GO);
   localparam logic [IDX_W-1:0] C_OPCOND  = IDX_W'(OP_OPCOND);
   localparam logic [IDX_W-1:0] C_ALLID   = IDX_W'(OP_ALLID);
   localparam logic [IDX_W-1:0] C_SETADDR = IDX_W'(OP_SETADDR);
   localparam logic [IDX_W-1:0] C_SELECT  = IDX_W'(OP_SELECT);
   localparam logic [IDX_W-1:0] C_STATUS  = IDX_W'(OP_STATUS);
   localparam logic [IDX_W-1:0] C_WR_ONE  = IDX_W'(OP_WR_ONE);
   localparam logic [IDX_W-1:0] C_WR_MANY = IDX_W'(OP_WR_MANY);
   localparam logic [ARG_W-1:0] C_BOOT    = ARG_W'(BOOT_ARG);

   mmcst_state_e st_q, st_d;
   logic due_d, ill_d;
   logic zero_blk;
   logic id_cmd;

   generate
      if (ZERO_RCA_REJECT) begin : g_zero_reject
         assign zero_blk = zero_i;
      end else begin : g_zero_accept
         assign zero_blk = 1'b0 & zero_i;
      end
   endgenerate

   assign id_cmd = (idx_i == C_OPCOND) || (idx_i == C_ALLID) || (idx_i == C_SETADDR);

   always_comb begin
      st_d        = st_q;
      due_d       = 1'b0;
      ill_d       = 1'b0;
      rca_load_o  = 1'b0;
      rca_clear_o = 1'b0;
      if (cmd_valid_i) begin
         if (idx_i == C_GO) begin
            if (arg_i == C_BOOT && st_q == ST_IDLE) begin
               st_d = ST_BOOT;
            end else begin
               st_d        = ST_IDLE;
               rca_clear_o = 1'b1;
            end
         end else if (st_q == ST_BOOT) begin
            st_d = ST_BOOT;
         end else if (id_cmd && rca_set_i) begin
            st_d = st_q;
         end else begin
            case (idx_i)
               C_OPCOND:
                  if (st_q == ST_IDLE) begin st_d = ST_READY; due_d = 1'b1; end
                  else ill_d = 1'b1;
               C_ALLID:
                  if (st_q == ST_READY) begin st_d = ST_IDENT; due_d = 1'b1; end
                  else ill_d = 1'b1;
               C_SETADDR:
                  if (st_q == ST_IDENT && !zero_blk) begin
                     st_d = ST_STBY; due_d = 1'b1; rca_load_o = 1'b1;
                  end else ill_d = 1'b1;
               C_SELECT:
                  case (st_q)
                     ST_STBY: if (own_i) begin st_d = ST_TRAN; due_d = 1'b1; end
                     ST_TRAN: if (own_i) ill_d = 1'b1; else st_d = ST_STBY;
                     ST_DIS:  if (own_i) begin st_d = ST_PRG; due_d = 1'b1; end
                     ST_PRG:  if (own_i) ill_d = 1'b1; else st_d = ST_DIS;
                     default: ill_d = 1'b1;
                  endcase
               C_STATUS:
                  if (is_addressed_state(st_q)) due_d = own_i;
                  else ill_d = 1'b1;
               C_WR_ONE, C_WR_MANY:
                  if (st_q == ST_TRAN) begin st_d = ST_PRG; due_d = 1'b1; end
                  else ill_d = 1'b1;
               default: ill_d = 1'b1;
            endcase
         end
      end else if (busy_done_i) begin
         if (st_q == ST_PRG)      st_d = ST_TRAN;
         else if (st_q == ST_DIS) st_d = ST_STBY;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         rsp_valid_o <= 1'b0;
         rsp_due_o   <= 1'b0;
         illegal_o   <= 1'b0;
      end else begin
         st_q        <= st_d;
         rsp_valid_o <= cmd_valid_i;
         rsp_due_o   <= due_d;
         illegal_o   <= ill_d;
      end
   end

   assign state_o = st_q;

   // R14: a command is never both answered and illegal
   a_r14_due_xor_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> !(rsp_due_o && illegal_o));
   // R4: own address selects from stand-by
   a_r4_select: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && idx_i == C_SELECT && st_q == ST_STBY && own_i)
      |=> (st_q == ST_TRAN) && rsp_due_o);
   // R6: own address in transfer is illegal and state holds
   a_r6_tran_own: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && idx_i == C_SELECT && st_q == ST_TRAN && own_i)
      |=> (st_q == ST_TRAN) && illegal_o && !rsp_due_o);
   // R8: own address in programming is illegal and state holds
   a_r8_prg_own: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && idx_i == C_SELECT && st_q == ST_PRG && own_i)
      |=> (st_q == ST_PRG) && illegal_o && !rsp_due_o);
   // R9: identification commands are silent after address assignment
   a_r9_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && id_cmd && rca_set_i && st_q != ST_BOOT)
      |=> !rsp_due_o && !illegal_o && $stable(st_q));
   // R10: plain reset command always reaches idle
   a_r10_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && idx_i == C_GO && arg_i == '0) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/mmc_state_tracker.sv
module mmc_state_tracker
   import mmcst_pkg::*;
#(
   parameter int unsigned IDX_W           = 6,
   parameter int unsigned ARG_W           = 32,
   parameter int unsigned RCA_W           = 16,
   parameter logic [31:0] BOOT_ARG        = 32'hFFFF_FFFA,
   parameter bit          ZERO_RCA_REJECT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [IDX_W-1:0] cmd_idx,
   input  logic [ARG_W-1:0] cmd_arg,
   input  logic             busy_done,
   output logic             rsp_valid,
   output logic             rsp_due,
   output logic             cmd_illegal,
   output logic [3:0]       card_state,
   output logic [RCA_W-1:0] card_rca
);
   localparam int unsigned RCA_LSB = ARG_W - RCA_W;

   generate
      if (RCA_W < 1 || RCA_W > ARG_W) begin : g_bad_rca_w
         $error("RCA_W must lie in 1..ARG_W");
      end
      if (IDX_W < 5) begin : g_bad_idx_w
         $error("IDX_W must hold index 25");
      end
   endgenerate

   logic [RCA_W-1:0] field;
   logic own, zero, rca_set, rca_load, rca_clear;
   mmcst_state_e st;

   assign field = cmd_arg[RCA_LSB +: RCA_W];

   mmcst_addr_match #(.RCA_W(RCA_W)) u_match (
      .field_i(field), .rca_i(card_rca), .rca_set_i(rca_set),
      .own_o(own), .zero_o(zero)
   );

   mmcst_rca_reg #(.RCA_W(RCA_W)) u_rca (
      .clk(clk), .rst_n(rst_n), .load_i(rca_load), .clear_i(rca_clear),
      .din_i(field), .rca_o(card_rca), .rca_set_o(rca_set)
   );

   mmcst_fsm #(
      .IDX_W(IDX_W), .ARG_W(ARG_W), .BOOT_ARG(BOOT_ARG),
      .ZERO_RCA_REJECT(ZERO_RCA_REJECT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .idx_i(cmd_idx),
      .arg_i(cmd_arg), .busy_done_i(busy_done), .own_i(own), .zero_i(zero),
      .rca_set_i(rca_set), .rca_load_o(rca_load), .rca_clear_o(rca_clear),
      .state_o(st), .rsp_valid_o(rsp_valid), .rsp_due_o(rsp_due),
      .illegal_o(cmd_illegal)
   );

   assign card_state = st;
endmodule

// File: tb/mmc_state_tracker_tb_top.sv
module mmc_state_tracker_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [5:0]  cmd_idx = '0;
   logic [31:0] cmd_arg = '0;
   logic        busy_done = 1'b0;
   logic        rsp_valid, rsp_due, cmd_illegal;
   logic [3:0]  card_state;
   logic [15:0] card_rca;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [21:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   mmc_state_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
      .cmd_arg(cmd_arg), .busy_done(busy_done), .rsp_valid(rsp_valid),
      .rsp_due(rsp_due), .cmd_illegal(cmd_illegal), .card_state(card_state),
      .card_rca(card_rca)
   );

   // driver: push expected outcome, then strobe the command for one cycle
   task automatic send(input int idx, input logic [31:0] arg, input bit due,
                       input bit ill, input logic [3:0] st, input logic [15:0] rca,
                       input string tag);
      exp_q.push_back({due, ill, st, rca});
      tag_q.push_back(tag);
      cmd_idx   = 6'(idx);
      cmd_arg   = arg;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic busy_pulse(input logic [3:0] st, input string tag);
      busy_done = 1'b1;
      @(negedge clk);
      busy_done = 1'b0;
      total++;
      if (card_state !== st) begin
         bad++;
         $display("FAIL %s state act=%0d exp=%0d", tag, card_state, st);
      end
   endtask

   // monitor: compare each outcome against the queue head
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected outcome act=%b exp=none", rsp_valid);
         end else begin
            automatic logic [21:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            automatic logic [21:0] a = {rsp_due, cmd_illegal, card_state, card_rca};
            if (a !== e) begin
               bad++;
               $display("FAIL %s act due=%b ill=%b st=%0d rca=%h exp due=%b ill=%b st=%0d rca=%h",
                        t, a[21], a[20], a[19:16], a[15:0], e[21], e[20], e[19:16], e[15:0]);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      total++;
      if (card_state !== 4'd0 || card_rca !== 16'h0 || rsp_valid !== 1'b0) begin
         bad++;
         $display("FAIL R1 act st=%0d rca=%h v=%b exp st=0 rca=0 v=0", card_state, card_rca, rsp_valid);
      end
      send(2,  32'h0,          0, 1, 0,  16'h0,    "R14 idx2 in idle");
      send(0,  32'hFFFF_FFFA,  0, 0, 10, 16'h0,    "R11 boot entry");
      send(1,  32'h0,          0, 0, 10, 16'h0,    "R11 ignored in boot");
      send(0,  32'h0,          0, 0, 0,  16'h0,    "R10 leave boot");
      send(1,  32'h0,          1, 0, 1,  16'h0,    "R2 idle to ready");
      send(2,  32'h0,          1, 0, 2,  16'h0,    "R2 ready to ident");
      send(3,  32'h0000_0000,  0, 1, 2,  16'h0,    "R3 zero rca");
      send(3,  32'h1234_0000,  1, 0, 3,  16'h1234, "R2 rca assign");
      send(1,  32'h0,          0, 0, 3,  16'h1234, "R9 idx1 silent");
      send(3,  32'h5555_0000,  0, 0, 3,  16'h1234, "R9 idx3 silent");
      send(13, 32'h1234_0000,  1, 0, 3,  16'h1234, "R13 own status");
      send(13, 32'h4321_0000,  0, 0, 3,  16'h1234, "R13 other status");
      send(7,  32'h4321_0000,  0, 0, 3,  16'h1234, "R4 other addr stby");
      send(7,  32'h1234_0000,  1, 0, 4,  16'h1234, "R4 select");
      send(7,  32'h1234_0000,  0, 1, 4,  16'h1234, "R6 own in tran");
      send(7,  32'h0000_0000,  0, 0, 3,  16'h1234, "R5 zero deselect");
      send(7,  32'h1234_0000,  1, 0, 4,  16'h1234, "R4 reselect");
      send(7,  32'h7777_0000,  0, 0, 3,  16'h1234, "R5 other deselect");
      send(7,  32'h1234_0000,  1, 0, 4,  16'h1234, "R4 reselect2");
      send(24, 32'h0,          1, 0, 7,  16'h1234, "R12 write one");
      busy_pulse(4, "R12 prg done");
      send(25, 32'h0,          1, 0, 7,  16'h1234, "R12 write many");
      send(7,  32'h1234_0000,  0, 1, 7,  16'h1234, "R8 own in prg");
      send(7,  32'h9999_0000,  0, 0, 8,  16'h1234, "R7 prg to dis");
      send(7,  32'h1234_0000,  1, 0, 7,  16'h1234, "R7 dis to prg");
      send(7,  32'h0000_0000,  0, 0, 8,  16'h1234, "R7 prg zero to dis");
      busy_pulse(3, "R12 dis done");
      busy_pulse(3, "R12 busy in stby");
      send(24, 32'h0,          0, 1, 3,  16'h1234, "R14 write in stby");
      send(9,  32'h1234_0000,  0, 1, 3,  16'h1234, "R14 unsupported");
      send(0,  32'hFFFF_FFFA,  0, 0, 0,  16'h0,    "R11 boot arg outside idle");
      send(1,  32'h0,          1, 0, 1,  16'h0,    "R10 rca cleared reenter");
      send(0,  32'h0,          0, 0, 0,  16'h0,    "R10 reset from ready");
      @(negedge clk);
      total++;
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R2 missing outcomes act=%0d exp=0", exp_q.size());
      end
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule